// File: doc/BRIEF.md
# L1 Write-Ownership Hold Timer and Request State Logic

This block is the core-facing state logic of a token-coherent first-level cache controller. Each core request carries a kind: load, instruction fetch, store or atomic. A classifier turns it into an event class. The event class and the current state of the addressed line decide the outcome. A request can complete as a hit, be sent back for retry, or start a miss. Every miss takes an entry in a small associative miss table. That entry records whether the request that opened it was an atomic.

When a write miss is filled, the line enters a waiting state and the entry's hold timer is armed. While the timer runs, the controller keeps ownership of the line. When the timer expires, the block raises a one-cycle expiry event and frees the entry. If another node's persistent request holds the line locked, the event is a starver event and the line gives up its tokens. Otherwise the line settles in one of two exclusive states. In the migratory exclusive state, a later reader may take write permission. In the non-migratory exclusive state, readers get read permission only.

A configuration input decides whether atomics form their own class. When they do, atomic accesses and expiries that follow an atomic miss settle in the non-migratory state. This keeps a locked line from being taken away by an ordinary load.

Top module: `l1ut_ctrl`

## Requirements
- R1: After reset, every line reads state code 0. The state codes are: ABS 0, INV 1, SHR 2, OWN 3, EXC 4, MIG 5, EXC_W 6, MIG_W 7, RD_PEND 8, WR_PEND 9, SH_UPG 10, OW_UPG 11. After reset `req_ready` is high and `evt_valid` is low.
- R2: Request kinds are encoded load 0, fetch 1, store 2, atomic 3. When `cfg_nomig` is low, an atomic behaves exactly like a store. For example, an atomic hit in MIG leaves the line in MIG.
- R3: A store or atomic to ABS or INV issues a write miss and moves the line to WR_PEND. From SHR it moves to SH_UPG, and from OWN it moves to OW_UPG. The output `miss_is_write` is high, and a table entry is taken.
- R4: Any request to RD_PEND, WR_PEND, SH_UPG or OW_UPG, or to a line whose expiry is being handled in that cycle, is recycled. The line state does not change, and no miss is issued.
- R5: When `cfg_nomig` is high, an atomic hit in MIG completes and moves the line to EXC. A store hit in MIG completes and leaves the line in MIG.
- R6: A store hit in EXC_W moves the line to MIG_W, and an atomic hit leaves it in EXC_W. An atomic hit in EXC stays in EXC, and a store hit in EXC moves the line to MIG.
- R7: A fill to WR_PEND, SH_UPG or OW_UPG moves the line to MIG_W and arms the timer. A fill to RD_PEND with `fill_all_tok` high moves the line to EXC_W and arms the timer. With `fill_all_tok` low, it moves the line to SHR and frees the entry. A fill to any other state is ignored.
- R8: On expiry with `lock_other` low, the event code is 1 (keep exclusive) if the entry was opened by an atomic and `cfg_nomig` is high, and 0 otherwise. MIG_W then moves to EXC on code 1 and to MIG on code 0.
- R9: On expiry with `lock_other` low, EXC_W moves to EXC for either event code. Every expiry frees its table entry.
- R10: On expiry with `lock_other` high, the event code is 2 if `lock_write` is high and 3 if it is low. Code 2 moves the line to INV, and code 3 moves it to OWN.
- R11: The expiry event is first visible TIMEOUT-1 cycles after the clock edge that takes the fill. The line state changes at the following edge. The event only ever names a line in EXC_W or MIG_W.
- R12: `req_ready` is low while every table entry is in use, and it rises again once an entry is freed.
- R13: A load or fetch to ABS or INV issues a read miss and moves the line to RD_PEND. A load or fetch to SHR, OWN, EXC, MIG, EXC_W or MIG_W completes as a hit with no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nomig | input | 1 | Treat atomics as a separate, non-migrating class |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | Request kind (load, fetch, store, atomic) |
| req_line | input | LINE_W | Line addressed by the request |
| req_ready | output | 1 | A table entry is free; request may be accepted |
| rsp_done | output | 1 | Request completed as a hit this cycle |
| rsp_recycle | output | 1 | Request must be retried later |
| miss_issue | output | 1 | Miss issued for the request |
| miss_is_write | output | 1 | Issued miss is a write request |
| fill_valid | input | 1 | Miss data and tokens arrived |
| fill_line | input | LINE_W | Line receiving the fill |
| fill_all_tok | input | 1 | A read fill brought every token |
| lock_other | input | 1 | Line under expiry is locked by another node's persistent request |
| lock_write | input | 1 | Smallest locking requester wants write access |
| evt_valid | output | 1 | Hold-timer expiry event this cycle |
| evt_code | output | 2 | Expiry event kind |
| evt_line | output | LINE_W | Line of the expiry event |
| line_state | output | 4*NUM_LINES | State code of each line, line i at bits 4i+3..4i |

## Verification
The bench targets the split between the migratory and non-migratory outcomes. A design that ignored the entry's atomic bit, or ignored `cfg_nomig`, would leave a line in MIG after an atomic miss or after an atomic hit. It would also report code 0 where code 1 belongs. Recycling in pending states is checked at the ports: a design that let a second store through would issue a duplicate miss or change the state code. Both expiries are timed to the exact cycle, so an off-by-one timer load shifts the event. The full-table case shows whether `req_ready` stalls and then recovers when an entry frees. The starver cases check that a lock overrides the atomic rule and sends the line to INV or OWN.

// File: rtl/l1ut_pkg.sv
package l1ut_pkg;

   typedef enum logic [3:0] {
      ST_ABS     = 4'd0,
      ST_INV     = 4'd1,
      ST_SHR     = 4'd2,
      ST_OWN     = 4'd3,
      ST_EXC     = 4'd4,
      ST_MIG     = 4'd5,
      ST_EXC_W   = 4'd6,
      ST_MIG_W   = 4'd7,
      ST_RD_PEND = 4'd8,
      ST_WR_PEND = 4'd9,
      ST_SH_UPG  = 4'd10,
      ST_OW_UPG  = 4'd11
   } line_st_e;

   typedef enum logic [1:0] {
      RK_LOAD   = 2'd0,
      RK_FETCH  = 2'd1,
      RK_STORE  = 2'd2,
      RK_ATOMIC = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      EV_READ   = 2'd0,
      EV_STORE  = 2'd1,
      EV_ATOMIC = 2'd2
   } req_class_e;

   typedef enum logic [1:0] {
      TO_PLAIN  = 2'd0,
      TO_KEEPX  = 2'd1,
      TO_STARVX = 2'd2,
      TO_STARVS = 2'd3
   } expiry_e;

   localparam int ST_W = 4;

endpackage

// File: rtl/l1ut_classify.sv
module l1ut_classify
   import l1ut_pkg::*;
#(
   parameter bit ATOMIC_CLASS_EN = 1'b1
) (
   input  logic [1:0] kind,
   input  logic       cfg_nomig,
   output req_class_e cls
);

   generate
      if (ATOMIC_CLASS_EN) begin : g_split
         always_comb begin
            case (kind)
               RK_LOAD, RK_FETCH: cls = EV_READ;
               RK_STORE:          cls = EV_STORE;
               default:           cls = cfg_nomig ? EV_ATOMIC : EV_STORE;
            endcase
         end
      end else begin : g_merged
         logic unused_cfg;
         assign unused_cfg = cfg_nomig;
         always_comb begin
            case (kind)
               RK_LOAD, RK_FETCH: cls = EV_READ;
               default:           cls = EV_STORE;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/l1ut_mshr.sv
module l1ut_mshr #(
   parameter int NUM_ENT = 2,
   parameter int LINE_W  = 2,
   parameter int TIMEOUT = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [LINE_W-1:0] alloc_line,
   input  logic              alloc_atomic,
   input  logic              arm_en,
   input  logic [LINE_W-1:0] arm_line,
   input  logic              free_en,
   input  logic [LINE_W-1:0] free_line,
   output logic              full,
   output logic              exp_valid,
   output logic [LINE_W-1:0] exp_line,
   output logic              exp_atomic
);

   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT - 1);

   generate
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("l1ut_mshr: TIMEOUT must be at least 2");
      end
      if (NUM_ENT < 1) begin : g_bad_depth
         $error("l1ut_mshr: NUM_ENT must be at least 1");
      end
   endgenerate

   typedef struct packed {
      logic              vld;
      logic              atom;
      logic              armed;
      logic [LINE_W-1:0] line;
      logic [CNT_W-1:0]  cnt;
   } ent_t;

   ent_t             ent_q [NUM_ENT];
   logic [IDX_W-1:0] alloc_idx;
   logic [IDX_W-1:0] exp_idx;

   always_comb begin
      full      = 1'b1;
      alloc_idx = '0;
      exp_valid = 1'b0;
      exp_idx   = '0;
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
         if (!ent_q[i].vld) begin
            full      = 1'b0;
            alloc_idx = IDX_W'(i);
         end
         if (ent_q[i].vld && ent_q[i].armed && ent_q[i].cnt == '0) begin
            exp_valid = 1'b1;
            exp_idx   = IDX_W'(i);
         end
      end
   end

   assign exp_line   = ent_q[exp_idx].line;
   assign exp_atomic = ent_q[exp_idx].atom;

   genvar g;
   generate
      for (g = 0; g < NUM_ENT; g++) begin : g_ent
         logic kill;
         assign kill = (exp_valid && exp_idx == IDX_W'(g)) ||
                       (free_en && ent_q[g].vld && ent_q[g].line == free_line);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_q[g] <= '0;
            end else if (kill) begin
               ent_q[g].vld   <= 1'b0;
               ent_q[g].armed <= 1'b0;
            end else if (alloc_en && !ent_q[g].vld && alloc_idx == IDX_W'(g)) begin
               ent_q[g].vld   <= 1'b1;
               ent_q[g].atom  <= alloc_atomic;
               ent_q[g].armed <= 1'b0;
               ent_q[g].line  <= alloc_line;
               ent_q[g].cnt   <= '0;
            end else if (arm_en && ent_q[g].vld && ent_q[g].line == arm_line) begin
               ent_q[g].armed <= 1'b1;
               ent_q[g].cnt   <= LOAD_VAL;
            end else if (ent_q[g].armed && ent_q[g].cnt != '0) begin
               ent_q[g].cnt <= ent_q[g].cnt - 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/l1ut_ctrl.sv
module l1ut_ctrl
   import l1ut_pkg::*;
#(
   parameter int  NUM_LINES = 4,
   parameter int  NUM_ENT   = 2,
   parameter int  TIMEOUT   = 100,
   localparam int LINE_W    = $clog2(NUM_LINES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_nomig,
   input  logic                      req_valid,
   input  logic [1:0]                req_kind,
   input  logic [LINE_W-1:0]         req_line,
   output logic                      req_ready,
   output logic                      rsp_done,
   output logic                      rsp_recycle,
   output logic                      miss_issue,
   output logic                      miss_is_write,
   input  logic                      fill_valid,
   input  logic [LINE_W-1:0]         fill_line,
   input  logic                      fill_all_tok,
   input  logic                      lock_other,
   input  logic                      lock_write,
   output logic                      evt_valid,
   output logic [1:0]                evt_code,
   output logic [LINE_W-1:0]         evt_line,
   output logic [ST_W*NUM_LINES-1:0] line_state
);

   generate
      if (NUM_LINES < 2 || (1 << LINE_W) != NUM_LINES) begin : g_bad_lines
         $error("l1ut_ctrl: NUM_LINES must be a power of two, at least 2");
      end
      if (NUM_ENT > NUM_LINES) begin : g_bad_ent
         $error("l1ut_ctrl: NUM_ENT may not exceed NUM_LINES");
      end
   endgenerate

   line_st_e   st_q [NUM_LINES];
   req_class_e cls;
   logic       full;
   logic       exp_valid;
   logic [LINE_W-1:0] exp_line;
   logic       exp_atomic;
   logic       acc;
   line_st_e   cur_st, fill_st, exp_st;
   line_st_e   req_nxt, fill_nxt, exp_nxt;
   logic       arm_en, free_en;
   expiry_e    code;

   l1ut_classify #(.ATOMIC_CLASS_EN(1'b1)) u_cls (
      .kind      (req_kind),
      .cfg_nomig (cfg_nomig),
      .cls       (cls)
   );

   l1ut_mshr #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W), .TIMEOUT(TIMEOUT)) u_mshr (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_en     (miss_issue),
      .alloc_line   (req_line),
      .alloc_atomic (req_kind == RK_ATOMIC),
      .arm_en       (arm_en),
      .arm_line     (fill_line),
      .free_en      (free_en),
      .free_line    (fill_line),
      .full         (full),
      .exp_valid    (exp_valid),
      .exp_line     (exp_line),
      .exp_atomic   (exp_atomic)
   );

   assign req_ready = !full;
   assign acc       = req_valid && req_ready;
   assign cur_st    = st_q[req_line];
   assign fill_st   = st_q[fill_line];
   assign exp_st    = st_q[exp_line];

   // Core request: hit, retry or miss
   always_comb begin
      rsp_done      = 1'b0;
      rsp_recycle   = 1'b0;
      miss_issue    = 1'b0;
      miss_is_write = 1'b0;
      req_nxt       = cur_st;
      if (acc) begin
         if (exp_valid && exp_line == req_line) begin
            rsp_recycle = 1'b1;
         end else begin
            case (cur_st)
               ST_ABS, ST_INV: begin
                  miss_issue = 1'b1;
                  if (cls == EV_READ) begin
                     req_nxt = ST_RD_PEND;
                  end else begin
                     miss_is_write = 1'b1;
                     req_nxt       = ST_WR_PEND;
                  end
               end
               ST_SHR, ST_OWN: begin
                  if (cls == EV_READ) begin
                     rsp_done = 1'b1;
                  end else begin
                     miss_issue    = 1'b1;
                     miss_is_write = 1'b1;
                     req_nxt       = (cur_st == ST_SHR) ? ST_SH_UPG : ST_OW_UPG;
                  end
               end
               ST_EXC: begin
                  rsp_done = 1'b1;
                  if (cls == EV_STORE) req_nxt = ST_MIG;
               end
               ST_MIG: begin
                  rsp_done = 1'b1;
                  if (cls == EV_ATOMIC) req_nxt = ST_EXC;
               end
               ST_EXC_W: begin
                  rsp_done = 1'b1;
                  if (cls == EV_STORE) req_nxt = ST_MIG_W;
               end
               ST_MIG_W: rsp_done = 1'b1;
               default:  rsp_recycle = 1'b1;
            endcase
         end
      end
   end

   // Fill of an outstanding miss
   always_comb begin
      fill_nxt = fill_st;
      arm_en   = 1'b0;
      free_en  = 1'b0;
      if (fill_valid) begin
         case (fill_st)
            ST_RD_PEND: begin
               if (fill_all_tok) begin
                  fill_nxt = ST_EXC_W;
                  arm_en   = 1'b1;
               end else begin
                  fill_nxt = ST_SHR;
                  free_en  = 1'b1;
               end
            end
            ST_WR_PEND, ST_SH_UPG, ST_OW_UPG: begin
               fill_nxt = ST_MIG_W;
               arm_en   = 1'b1;
            end
            default: fill_nxt = fill_st;
         endcase
      end
   end

   // Hold-timer expiry
   always_comb begin
      if (lock_other)
         code = lock_write ? TO_STARVX : TO_STARVS;
      else if (exp_atomic && cfg_nomig)
         code = TO_KEEPX;
      else
         code = TO_PLAIN;
      case (code)
         TO_STARVX: exp_nxt = ST_INV;
         TO_STARVS: exp_nxt = ST_OWN;
         default: begin
            if (exp_st == ST_MIG_W)
               exp_nxt = (code == TO_KEEPX) ? ST_EXC : ST_MIG;
            else if (exp_st == ST_EXC_W)
               exp_nxt = ST_EXC;
            else
               exp_nxt = exp_st;
         end
      endcase
   end

   assign evt_valid = exp_valid;
   assign evt_code  = code;
   assign evt_line  = exp_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LINES; i++) st_q[i] <= ST_ABS;
      end else begin
         for (int i = 0; i < NUM_LINES; i++) begin
            if (acc && req_line == LINE_W'(i) && (rsp_done || miss_issue))
               st_q[i] <= req_nxt;
            else if (fill_valid && fill_line == LINE_W'(i))
               st_q[i] <= fill_nxt;
            else if (exp_valid && exp_line == LINE_W'(i))
               st_q[i] <= exp_nxt;
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < NUM_LINES; g++) begin : g_out
         assign line_state[ST_W*g +: ST_W] = st_q[g];
      end
   endgenerate

endmodule

// File: rtl/l1ut_ctrl_chk.sv
module l1ut_ctrl_chk #(
   parameter int  NUM_LINES = 4,
   localparam int LINE_W    = $clog2(NUM_LINES)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_ready,
   input logic                   rsp_done,
   input logic                   rsp_recycle,
   input logic                   miss_issue,
   input logic                   fill_valid,
   input logic                   lock_other,
   input logic                   evt_valid,
   input logic [1:0]             evt_code,
   input logic [LINE_W-1:0]      evt_line,
   input logic [4*NUM_LINES-1:0] line_state
);

   logic [3:0]        ev_st;
   logic              last_v;
   logic [1:0]        last_code;
   logic [LINE_W-1:0] last_line;
   logic [3:0]        last_st;

   assign ev_st   = line_state[{evt_line, 2'b00} +: 4];
   assign last_st = line_state[{last_line, 2'b00} +: 4];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_v    <= 1'b0;
         last_code <= '0;
         last_line <= '0;
      end else begin
         last_v    <= evt_valid && ev_st == 4'd7;
         last_code <= evt_code;
         last_line <= evt_line;
      end
   end

   // R3: a miss is only issued for an accepted request
   a_r3_issue_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      miss_issue |-> (req_valid && req_ready));

   // R4: at most one response kind per cycle
   a_r4_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_done, rsp_recycle, miss_issue}));

   // R8: keep-exclusive expiry of a migratory waiting line lands in EXC
   a_r8_keepx_to_exc: assert property (@(posedge clk) disable iff (!rst_n)
      (last_v && last_code == 2'd1) |-> (last_st == 4'd4));

   // R10: a foreign lock always yields a starver code
   a_r10_starver_code: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && lock_other) |-> evt_code[1]);

   // R11: expiry only names a waiting line
   a_r11_waiting_line: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (ev_st == 4'd6 || ev_st == 4'd7));

   // R12: with no free entry and nothing freeing one, ready stays low
   a_r12_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !evt_valid && !fill_valid) |=> !req_ready);

endmodule

bind l1ut_ctrl l1ut_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_done    (rsp_done),
   .rsp_recycle (rsp_recycle),
   .miss_issue  (miss_issue),
   .fill_valid  (fill_valid),
   .lock_other  (lock_other),
   .evt_valid   (evt_valid),
   .evt_code    (evt_code),
   .evt_line    (evt_line),
   .line_state  (line_state)
);

// File: tb/l1ut_ctrl_tb.sv
`timescale 1ns/1ps
module l1ut_ctrl_tb;

   localparam int NL = 4;
   localparam int NE = 2;
   localparam int T  = 12;
   localparam int LW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_nomig = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [LW-1:0] req_line = '0;
   logic          req_ready, rsp_done, rsp_recycle, miss_issue, miss_is_write;
   logic          fill_valid = 1'b0;
   logic [LW-1:0] fill_line = '0;
   logic          fill_all_tok = 1'b0;
   logic          lock_other = 1'b0;
   logic          lock_write = 1'b0;
   logic          evt_valid;
   logic [1:0]    evt_code;
   logic [LW-1:0] evt_line;
   logic [4*NL-1:0] line_state;

   int nvec = 0;
   int nfail = 0;
   int cyc = 0;
   int fill_cyc = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   l1ut_ctrl #(.NUM_LINES(NL), .NUM_ENT(NE), .TIMEOUT(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_nomig(cfg_nomig),
      .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_recycle(rsp_recycle),
      .miss_issue(miss_issue), .miss_is_write(miss_is_write),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_all_tok(fill_all_tok),
      .lock_other(lock_other), .lock_write(lock_write),
      .evt_valid(evt_valid), .evt_code(evt_code), .evt_line(evt_line),
      .line_state(line_state)
   );

   typedef struct packed {
      logic       op;
      logic [1:0] kind;
      logic [1:0] line;
      logic       all_tok;
      logic       e_done;
      logic       e_rec;
      logic       e_iss;
      logic       e_wr;
      logic [3:0] e_st;
   } vec_t;

   // op 0 = request, op 1 = fill
   localparam int NV = 7;
   localparam vec_t TAB [NV] = '{
      '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8},
      '{1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},
      '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
      '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
      '{1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10},
      '{1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10},
      '{1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9}
   };
   localparam string TAG [NV] = '{"R13", "R4", "R7", "R13", "R3", "R4", "R3"};

   function automatic logic [3:0] st_of(input int ln);
      return line_state[4*ln +: 4];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic chkv(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   // Response encoded as {done, recycle, issue, write}
   task automatic do_req(input logic [1:0] k, input int ln, input logic [3:0] e_rsp,
                         input logic [3:0] e_st, input string tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = k;
      req_line  = LW'(ln);
      #1;
      chkv({tag, " response"}, int'({rsp_done, rsp_recycle, miss_issue, miss_is_write}), int'(e_rsp));
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      chkv({tag, " state"}, int'(st_of(ln)), int'(e_st));
   endtask

   task automatic do_fill(input int ln, input logic all, input logic [3:0] e_st,
                          input string tag);
      @(negedge clk);
      fill_valid   = 1'b1;
      fill_line    = LW'(ln);
      fill_all_tok = all;
      @(posedge clk);
      #1;
      fill_cyc   = cyc;
      fill_valid = 1'b0;
      chkv({tag, " fill state"}, int'(st_of(ln)), int'(e_st));
   endtask

   task automatic wait_evt(input int base, input int ln, input int e_code,
                           input logic [3:0] e_st, input string tag);
      for (int n = 0; n < 4 * T; n++) begin
         @(negedge clk);
         if (evt_valid) break;
      end
      chkv({tag, " evt seen"}, int'(evt_valid), 1);
      chkv("R11 expiry timing", cyc - base, T - 1);
      chkv({tag, " evt line"}, int'(evt_line), ln);
      chkv({tag, " evt code"}, int'(evt_code), e_code);
      chkv({tag, " pre-expiry state"}, int'(st_of(ln)) & 4'hE, 6);
      @(posedge clk);
      #1;
      chkv({tag, " post-expiry state"}, int'(st_of(ln)), int'(e_st));
   endtask

   initial begin : watchdog
      #(4 * 20000);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin : main
      int c0, c1;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chkv("R1 ready", int'(req_ready), 1);
      chkv("R1 evt", int'(evt_valid), 0);
      chkv("R1 states", int'(line_state), 0);

      for (int v = 0; v < NV; v++) begin
         if (TAB[v].op) begin
            do_fill(int'(TAB[v].line), TAB[v].all_tok, TAB[v].e_st, TAG[v]);
         end else begin
            do_req(TAB[v].kind, int'(TAB[v].line),
                   {TAB[v].e_done, TAB[v].e_rec, TAB[v].e_iss, TAB[v].e_wr},
                   TAB[v].e_st, TAG[v]);
         end
      end

      // R12 both entries in use
      @(negedge clk);
      chkv("R12 ready low when full", int'(req_ready), 0);

      // R7 write fills arm timers; line 0 entry is atomic, line 1 is not
      do_fill(0, 1'b0, 4'd7, "R7");
      c0 = fill_cyc;
      do_fill(1, 1'b0, 4'd7, "R7");
      c1 = fill_cyc;
      wait_evt(c0, 0, 1, 4'd4, "R8 atomic");
      chkv("R12 ready after free", int'(req_ready), 1);
      wait_evt(c1, 1, 0, 4'd5, "R8 plain");

      do_req(2'd3, 1, 4'b1000, 4'd4, "R5 atomic MIG");
      do_req(2'd2, 0, 4'b1000, 4'd5, "R6 store EXC");
      do_req(2'd2, 0, 4'b1000, 4'd5, "R5 store MIG");
      cfg_nomig = 1'b0;
      do_req(2'd3, 0, 4'b1000, 4'd5, "R2 atomic as store");
      cfg_nomig = 1'b1;

      do_req(2'd0, 2, 4'b0010, 4'd8, "R13 load miss");
      do_fill(2, 1'b1, 4'd6, "R7 all tokens");
      do_req(2'd3, 2, 4'b1000, 4'd6, "R6 atomic EXC_W");
      do_req(2'd2, 2, 4'b1000, 4'd7, "R6 store EXC_W");
      wait_evt(fill_cyc, 2, 0, 4'd5, "R8 plain");
      do_req(2'd0, 2, 4'b1000, 4'd5, "R13 load hit");

      do_req(2'd0, 3, 4'b0010, 4'd8, "R13 load miss");
      do_fill(3, 1'b1, 4'd6, "R7 all tokens");
      lock_other = 1'b1;
      lock_write = 1'b0;
      wait_evt(fill_cyc, 3, 3, 4'd3, "R10 starve shared");
      lock_other = 1'b0;
      do_req(2'd2, 3, 4'b0011, 4'd11, "R3 store OWN");
      do_fill(3, 1'b0, 4'd7, "R7");
      lock_other = 1'b1;
      lock_write = 1'b1;
      wait_evt(fill_cyc, 3, 2, 4'd1, "R10 starve excl");
      lock_other = 1'b0;
      lock_write = 1'b0;
      do_req(2'd1, 3, 4'b0010, 4'd8, "R13 fetch miss INV");
      do_fill(3, 1'b1, 4'd6, "R7 all tokens");
      wait_evt(fill_cyc, 3, 0, 4'd4, "R9 EXC_W");
      do_req(2'd3, 3, 4'b1000, 4'd4, "R6 atomic EXC");
      do_fill(3, 1'b1, 4'd4, "R7 ignored fill");
      @(negedge clk);
      chkv("R9 entries freed", int'(req_ready), 1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule